// File: doc/BRIEF.md
# Secure-Element Bus Frame Field Classifier

This block sits behind an I2C byte-level decoder and watches the stream of bus events it produces: start, address phase for reading, address phase for writing, one data byte, and stop. Every transaction addressed to a secure authentication element is collected in a local buffer. At stop the block works out where each field of the frame lies, then emits one field tag per byte. Tags go out serially, one per clock, each with its byte value, and are followed by a single-cycle completion pulse.

A write frame opens with a word-address byte. For the command word address, a count byte follows, then the opcode, a one-byte first parameter, a two-byte second parameter, a data area of any length and a two-byte CRC. The block checks that the count byte matches the number of bytes received. A read frame carries a count, a payload and a two-byte CRC. The word address of the latest write is kept so that the next read can be interpreted. If that read follows a reset or command word address and its count is 4, its payload is a single status byte, which the block decodes. The CRC values themselves are not computed or checked.

Top module: `sef_frame_classifier`

## Requirements
- R1: After reset `tag_valid_o`, `frame_done_o`, `len_err_o` and `status_valid_o` are all low.
- R2: A write transaction that carries no data byte (a wake-up) produces no tag, no completion pulse and no length error, and does not change the remembered word address.
- R3: A command write (first byte 0x03) whose count byte equals the number of received bytes minus one is emitted after stop, one byte per cycle in arrival order, each with its byte value and a tag. Tag codes are: 0 word address, 1 count, 2 opcode, 3 parameter 1, 4 parameter 2, 5 data, 6 CRC, 7 status. Byte 0 is the word address and byte 1 the count. Among bytes 2 onward, the last two are CRC, and of the rest, byte 2 is the opcode, byte 3 parameter 1, bytes 4 and 5 parameter 2 and later bytes data. The last tag is followed in the next cycle by a one-cycle `frame_done_o`.
- R4: A command write whose count byte does not match emits only the word-address and count tags (at most two), then `frame_done_o` with `len_err_o` high.
- R5: A write whose first byte is 0x00 (reset), 0x01 (sleep) or 0x02 (idle) emits a single word-address tag for that byte, then `frame_done_o` with no length error.
- R6: A read transaction with at least one byte emits count (tag 1) for byte 0. Each later byte is tagged CRC (tag 6) if it is one of the last two, and data (tag 5) otherwise.
- R7: A read frame is a status frame when the remembered word address is 0x00 or 0x03, its count byte is 4 and it holds at least two bytes. Its byte 1 is then tagged status (tag 7), and `status_valid_o` is high with `frame_done_o`. `status_code_o` maps the byte as 0x00→0 success, 0x01→1 check-MAC failure, 0x03→2 parse error, 0x0F→3 execution error, 0x11→4 ready, 0xFF→5 communication error, any other value→7.
- R8: Each write with at least one byte remembers its first byte, and every read clears the remembered word address, so a second read with count 4 is not a status frame.
- R9: A frame of more than `BUF_DEPTH` bytes emits no tag and ends with `frame_done_o` and `len_err_o`. A frame of exactly `BUF_DEPTH` bytes is classified normally.
- R10: A start received while bytes are being collected discards the frame so far with no output. The address phase that follows begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Bus event present this cycle |
| evt_kind_i | input | 3 | Event kind: 0 start, 1 address read, 2 address write, 3 data, 4 stop |
| evt_byte_i | input | 8 | Byte value for a data event |
| tag_valid_o | output | 1 | A tagged byte is presented |
| tag_o | output | 3 | Field tag code of the presented byte |
| tag_byte_o | output | 8 | Value of the presented byte |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |
| len_err_o | output | 1 | Length error, valid with `frame_done_o` |
| status_valid_o | output | 1 | Frame was a status frame, valid with `frame_done_o` |
| status_code_o | output | 3 | Decoded status code |

## Verification
The bench builds the block with `BUF_DEPTH` set to 16 instead of 96. This brings the overflow path within reach of a 17-byte write, and lets a frame of exactly 16 bytes exercise the full-buffer boundary. A sequence of writes and reads drives the remembered word address through its set and clear transitions, so that both status and plain interpretations of count-4 responses occur. Separate directed frames cover the wake-up, the repeated-start abort and the overflow.

// File: rtl/sef_pkg.sv
package sef_pkg;

  typedef enum logic [2:0] {
    EV_START   = 3'd0,
    EV_ADDR_RD = 3'd1,
    EV_ADDR_WR = 3'd2,
    EV_DATA    = 3'd3,
    EV_STOP    = 3'd4
  } sef_evt_e;

  typedef enum logic [2:0] {
    TAG_WADDR  = 3'd0,
    TAG_COUNT  = 3'd1,
    TAG_OPCODE = 3'd2,
    TAG_PARAM1 = 3'd3,
    TAG_PARAM2 = 3'd4,
    TAG_DATA   = 3'd5,
    TAG_CRC    = 3'd6,
    TAG_STATUS = 3'd7
  } sef_tag_e;

  typedef enum logic [2:0] {
    STS_SUCCESS  = 3'd0,
    STS_MAC_FAIL = 3'd1,
    STS_PARSE    = 3'd2,
    STS_EXEC     = 3'd3,
    STS_READY    = 3'd4,
    STS_COMM     = 3'd5,
    STS_UNKNOWN  = 3'd7
  } sef_sts_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_WR, S_RD, S_EMIT, S_DONE
  } sef_state_e;

  localparam logic [7:0] WA_RESET = 8'h00;
  localparam logic [7:0] WA_CMD   = 8'h03;
  localparam logic [7:0] STS_LEN  = 8'h04;

endpackage

// File: rtl/sef_byte_buf.sv
module sef_byte_buf #(
  parameter int DEPTH = 96,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic [7:0]    byte_i,
  input  logic [CW-1:0] rd_idx_i,
  output logic [7:0]    rd_byte_o,
  output logic [7:0]    head0_o,
  output logic [7:0]    head1_o,
  output logic [CW-1:0] fill_o,
  output logic          ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    mem_q [DEPTH];
  logic [CW-1:0] fill_q;
  logic          ovf_q;
  logic          full;

  assign full = (fill_q == CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      ovf_q  <= 1'b0;
    end else if (clear_i) begin
      fill_q <= '0;
      ovf_q  <= 1'b0;
    end else if (push_i) begin
      if (full) ovf_q  <= 1'b1;
      else      fill_q <= fill_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !clear_i && !full) mem_q[fill_q[AW-1:0]] <= byte_i;
  end

  assign rd_byte_o = (rd_idx_i < CW'(DEPTH)) ? mem_q[rd_idx_i[AW-1:0]] : 8'h00;
  assign head0_o   = mem_q[0];
  assign head1_o   = mem_q[1];
  assign fill_o    = fill_q;
  assign ovf_o     = ovf_q;

endmodule

// File: rtl/sef_field_map.sv
module sef_field_map
  import sef_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic [CW-1:0] idx_i,
  input  logic [CW-1:0] fill_i,
  input  logic          rd_i,
  input  logic          sts_frame_i,
  output sef_tag_e      tag_o
);
  logic in_crc;

  // last two bytes of the frame
  assign in_crc = (32'(idx_i) + 32'd2 >= 32'(fill_i));

  always_comb begin
    tag_o = TAG_DATA;
    if (rd_i) begin
      if (idx_i == '0)                           tag_o = TAG_COUNT;
      else if (sts_frame_i && idx_i == CW'(1))   tag_o = TAG_STATUS;
      else if (in_crc)                           tag_o = TAG_CRC;
      else                                       tag_o = TAG_DATA;
    end else begin
      if (idx_i == '0)                           tag_o = TAG_WADDR;
      else if (idx_i == CW'(1))                  tag_o = TAG_COUNT;
      else if (in_crc)                           tag_o = TAG_CRC;
      else if (idx_i == CW'(2))                  tag_o = TAG_OPCODE;
      else if (idx_i == CW'(3))                  tag_o = TAG_PARAM1;
      else if (idx_i == CW'(4) || idx_i == CW'(5)) tag_o = TAG_PARAM2;
      else                                       tag_o = TAG_DATA;
    end
  end

endmodule

// File: rtl/sef_status_dec.sv
module sef_status_dec
  import sef_pkg::*;
(
  input  logic [7:0] byte_i,
  output sef_sts_e   code_o
);
  always_comb begin
    unique case (byte_i)
      8'h00:   code_o = STS_SUCCESS;
      8'h01:   code_o = STS_MAC_FAIL;
      8'h03:   code_o = STS_PARSE;
      8'h0F:   code_o = STS_EXEC;
      8'h11:   code_o = STS_READY;
      8'hFF:   code_o = STS_COMM;
      default: code_o = STS_UNKNOWN;
    endcase
  end
endmodule

// File: rtl/sef_frame_classifier.sv
module sef_frame_classifier
  import sef_pkg::*;
#(
  parameter int BUF_DEPTH = 96
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       evt_valid_i,
  input  logic [2:0] evt_kind_i,
  input  logic [7:0] evt_byte_i,
  output logic       tag_valid_o,
  output logic [2:0] tag_o,
  output logic [7:0] tag_byte_o,
  output logic       frame_done_o,
  output logic       len_err_o,
  output logic       status_valid_o,
  output logic [2:0] status_code_o
);
  localparam int CW = $clog2(BUF_DEPTH + 1);

  sef_state_e    state_q, state_d;
  logic [CW-1:0] idx_q, idx_d, last_q, last_d;
  logic          err_q, err_d, rd_q, rd_d, sts_q, sts_d;
  logic [7:0]    wa_q, wa_d;
  logic          wa_vld_q, wa_vld_d;

  logic          ev_start, ev_ard, ev_awr, ev_data, ev_stop;
  logic          collecting, buf_clear, buf_push;
  logic [7:0]    rd_byte, head0, head1;
  logic [CW-1:0] fill;
  logic          ovf, count_ok, sts_hit;
  logic [CW-1:0] elen;
  sef_tag_e      tag;
  sef_sts_e      sts_code;

  assign ev_start = evt_valid_i && (evt_kind_i == EV_START);
  assign ev_ard   = evt_valid_i && (evt_kind_i == EV_ADDR_RD);
  assign ev_awr   = evt_valid_i && (evt_kind_i == EV_ADDR_WR);
  assign ev_data  = evt_valid_i && (evt_kind_i == EV_DATA);
  assign ev_stop  = evt_valid_i && (evt_kind_i == EV_STOP);

  assign collecting = (state_q == S_WR) || (state_q == S_RD);
  assign buf_clear  = ev_start && (state_q inside {S_IDLE, S_ADDR, S_WR, S_RD});
  assign buf_push   = ev_data && collecting;

  sef_byte_buf #(.DEPTH(BUF_DEPTH), .CW(CW)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (buf_clear),
    .push_i    (buf_push),
    .byte_i    (evt_byte_i),
    .rd_idx_i  (idx_q),
    .rd_byte_o (rd_byte),
    .head0_o   (head0),
    .head1_o   (head1),
    .fill_o    (fill),
    .ovf_o     (ovf)
  );

  sef_field_map #(.CW(CW)) u_map (
    .idx_i       (idx_q),
    .fill_i      (fill),
    .rd_i        (rd_q),
    .sts_frame_i (sts_q),
    .tag_o       (tag)
  );

  sef_status_dec u_sts (
    .byte_i (head1),
    .code_o (sts_code)
  );

  assign count_ok = (fill >= CW'(2)) && (32'(head1) == 32'(fill) - 32'd1);
  assign sts_hit  = wa_vld_q && (wa_q == WA_RESET || wa_q == WA_CMD) &&
                    (head0 == STS_LEN) && (fill >= CW'(2)) && !ovf;

  // number of bytes to emit when the frame closes
  always_comb begin
    elen = '0;
    if (ovf)                 elen = '0;
    else if (state_q == S_RD) elen = fill;
    else if (head0 == WA_CMD) elen = count_ok ? fill : ((fill > CW'(2)) ? CW'(2) : fill);
    else                     elen = CW'(1);
  end

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    last_d   = last_q;
    err_d    = err_q;
    rd_d     = rd_q;
    sts_d    = sts_q;
    wa_d     = wa_q;
    wa_vld_d = wa_vld_q;
    unique case (state_q)
      S_IDLE: if (ev_start) state_d = S_ADDR;
      S_ADDR: begin
        if (ev_ard)       state_d = S_RD;
        else if (ev_awr)  state_d = S_WR;
        else if (ev_stop) state_d = S_IDLE;
      end
      S_WR, S_RD: begin
        if (ev_start) begin
          state_d = S_ADDR;
        end else if (ev_stop) begin
          if (state_q == S_RD) wa_vld_d = 1'b0;
          if (fill == '0) begin
            state_d = S_IDLE;
          end else begin
            rd_d  = (state_q == S_RD);
            sts_d = (state_q == S_RD) && sts_hit;
            err_d = ovf || ((state_q == S_WR) && (head0 == WA_CMD) && !count_ok);
            if (state_q == S_WR) begin
              wa_d     = head0;
              wa_vld_d = 1'b1;
            end
            idx_d = '0;
            if (elen == '0) begin
              state_d = S_DONE;
            end else begin
              last_d  = elen - CW'(1);
              state_d = S_EMIT;
            end
          end
        end
      end
      S_EMIT: begin
        if (idx_q == last_q) state_d = S_DONE;
        else                 idx_d   = idx_q + CW'(1);
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      last_q   <= '0;
      err_q    <= 1'b0;
      rd_q     <= 1'b0;
      sts_q    <= 1'b0;
      wa_q     <= 8'h00;
      wa_vld_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      last_q   <= last_d;
      err_q    <= err_d;
      rd_q     <= rd_d;
      sts_q    <= sts_d;
      wa_q     <= wa_d;
      wa_vld_q <= wa_vld_d;
    end
  end

  assign tag_valid_o    = (state_q == S_EMIT);
  assign tag_o          = tag_valid_o ? tag : 3'd0;
  assign tag_byte_o     = tag_valid_o ? rd_byte : 8'h00;
  assign frame_done_o   = (state_q == S_DONE);
  assign len_err_o      = frame_done_o && err_q;
  assign status_valid_o = frame_done_o && sts_q && !err_q;
  assign status_code_o  = status_valid_o ? sts_code : 3'd0;

endmodule

// File: rtl/sef_frame_classifier_chk.sv
module sef_frame_classifier_chk #(
  parameter int BUF_DEPTH = 96
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       evt_valid_i,
  input logic [2:0] evt_kind_i,
  input logic [7:0] evt_byte_i,
  input logic       tag_valid_o,
  input logic [2:0] tag_o,
  input logic [7:0] tag_byte_o,
  input logic       frame_done_o,
  input logic       len_err_o,
  input logic       status_valid_o,
  input logic [2:0] status_code_o
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           run_q <= 0;
    else if (frame_done_o) run_q <= 0;
    else if (tag_valid_o)  run_q <= run_q + 1;
  end

  p_done_excl_tag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_done_o && tag_valid_o));

  p_run_ends_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tag_valid_o) |-> frame_done_o);

  p_first_tag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tag_valid_o) |-> (tag_o == 3'd0 || tag_o == 3'd1));

  p_err_with_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |-> frame_done_o);

  p_err_short_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |-> run_q <= 2);

  p_sts_with_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_valid_o |-> (frame_done_o && !len_err_o));

  p_burst_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_valid_o |-> run_q < BUF_DEPTH);

  p_single_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o && !tag_valid_o);

endmodule

bind sef_frame_classifier sef_frame_classifier_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (.*);

// File: tb/sef_frame_classifier_bench.sv
module sef_frame_classifier_bench;

  localparam int DEPTH = 16;
  localparam int NV    = 15;
  // {kind[26:25] 0 cmd write,1 other write,2 read; b0; b1 (read only); len; bad count}
  localparam logic [26:0] VEC [NV] = '{
    {2'd0, 8'h03, 8'h00, 8'd10, 1'b0},
    {2'd2, 8'h0C, 8'h55, 8'd12, 1'b0},
    {2'd0, 8'h03, 8'h00, 8'd8,  1'b0},
    {2'd2, 8'h04, 8'h00, 8'd4,  1'b0},
    {2'd2, 8'h04, 8'h0F, 8'd4,  1'b0},
    {2'd0, 8'h03, 8'h00, 8'd9,  1'b1},
    {2'd2, 8'h04, 8'h11, 8'd4,  1'b0},
    {2'd1, 8'h00, 8'h00, 8'd1,  1'b0},
    {2'd2, 8'h04, 8'hFF, 8'd4,  1'b0},
    {2'd1, 8'h02, 8'h00, 8'd3,  1'b0},
    {2'd2, 8'h04, 8'h01, 8'd4,  1'b0},
    {2'd0, 8'h03, 8'h00, 8'd16, 1'b0},
    {2'd2, 8'h04, 8'h03, 8'd4,  1'b0},
    {2'd0, 8'h03, 8'h00, 8'd7,  1'b0},
    {2'd2, 8'h04, 8'h0F, 8'd4,  1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_valid = 1'b0;
  logic [2:0] ev_kind = 3'd0;
  logic [7:0] ev_byte = 8'h00;
  logic       tag_valid, frame_done, len_err, sts_valid;
  logic [2:0] tag, sts_code;
  logic [7:0] tag_byte;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [7:0] bytes_q [32];
  logic [2:0] got_tag [32];
  logic [7:0] got_byte [32];
  int         got_n;
  bit         got_done, got_err, got_stv;
  logic [2:0] got_code;

  bit         mem_vld = 1'b0;
  logic [7:0] mem_wa = 8'h00;

  always #5 clk = ~clk;

  sef_frame_classifier #(.BUF_DEPTH(DEPTH)) u_sef_frame_classifier (
    .clk_i (clk), .rst_ni (rst_n),
    .evt_valid_i (ev_valid), .evt_kind_i (ev_kind), .evt_byte_i (ev_byte),
    .tag_valid_o (tag_valid), .tag_o (tag), .tag_byte_o (tag_byte),
    .frame_done_o (frame_done), .len_err_o (len_err),
    .status_valid_o (sts_valid), .status_code_o (sts_code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [7:0] b);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_byte = b;
  endtask

  task automatic collect();
    got_n = 0; got_done = 0; got_err = 0; got_stv = 0; got_code = 3'd0;
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      ev_valid = 1'b0;
      if (tag_valid && got_n < 32) begin
        got_tag[got_n] = tag; got_byte[got_n] = tag_byte; got_n++;
      end
      if (frame_done) begin
        got_done = 1; got_err = len_err; got_stv = sts_valid; got_code = sts_code;
        break;
      end
    end
  endtask

  task automatic run_frame(input bit rd, input int n);
    send(3'd0, 8'h00);
    send(rd ? 3'd1 : 3'd2, 8'h00);
    for (int i = 0; i < n; i++) send(3'd3, bytes_q[i]);
    send(3'd4, 8'h00);
    collect();
  endtask

  function automatic logic [2:0] exp_code(input logic [7:0] b);
    case (b)
      8'h00: return 3'd0;
      8'h01: return 3'd1;
      8'h03: return 3'd2;
      8'h0F: return 3'd3;
      8'h11: return 3'd4;
      8'hFF: return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [2:0] exp_tag(input bit rd, input int i, input int n, input bit sts);
    if (rd) begin
      if (i == 0) return 3'd1;
      if (sts && i == 1) return 3'd7;
      if (i >= n - 2) return 3'd6;
      return 3'd5;
    end
    if (i == 0) return 3'd0;
    if (i == 1) return 3'd1;
    if (i >= n - 2) return 3'd6;
    if (i == 2) return 3'd2;
    if (i == 3) return 3'd3;
    if (i == 4 || i == 5) return 3'd4;
    return 3'd5;
  endfunction

  // model the frame from the requirements, run it and compare
  task automatic frame_check(input bit rd, input int n, input string req);
    int  en;
    bit  edone, eerr, ests;
    edone = (n != 0); eerr = 0; ests = 0; en = 0;
    if (n > DEPTH) begin
      eerr = 1; en = 0;
    end else if (n == 0) begin
      en = 0;
    end else if (rd) begin
      en = n;
      ests = mem_vld && (mem_wa == 8'h00 || mem_wa == 8'h03) && bytes_q[0] == 8'h04 && n >= 2;
    end else if (bytes_q[0] == 8'h03) begin
      if (n >= 2 && int'(bytes_q[1]) == n - 1) en = n;
      else begin en = (n > 2) ? 2 : n; eerr = 1; end
    end else begin
      en = 1;
    end
    run_frame(rd, n);
    check(got_done == edone, req, got_done, edone);
    check(got_n == en, req, got_n, en);
    for (int i = 0; i < en && i < got_n; i++) begin
      check(got_tag[i] == exp_tag(rd, i, n, ests), req, got_tag[i], exp_tag(rd, i, n, ests));
      check(got_byte[i] == bytes_q[i], req, got_byte[i], bytes_q[i]);
    end
    if (edone) begin
      check(got_err == eerr, req, got_err, eerr);
      check(got_stv == ests, req, got_stv, ests);
      if (ests) check(got_code == exp_code(bytes_q[1]), req, got_code, exp_code(bytes_q[1]));
    end
    if (rd) mem_vld = 0;
    else if (n >= 1) begin mem_vld = 1; mem_wa = bytes_q[0]; end
  endtask

  task automatic build(input logic [1:0] kind, input logic [7:0] b0, input logic [7:0] b1,
                       input int len, input bit bad);
    for (int i = 0; i < 32; i++)
      bytes_q[i] = (kind == 2'd2) ? 8'(8'hA0 + i) : 8'(8'h40 + i);
    bytes_q[0] = b0;
    if (kind == 2'd2) bytes_q[1] = b1;
    else bytes_q[1] = bad ? 8'(len) : 8'(len - 1);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!tag_valid && !frame_done && !len_err && !sts_valid, "R1",
          {tag_valid, frame_done, len_err, sts_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tag_valid && !frame_done, "R1", {tag_valid, frame_done}, 0);

    // table: R3 R4 R5 R6 R7 R8 R9 (16-byte boundary)
    for (int v = 0; v < NV; v++) begin
      build(VEC[v][26:25], VEC[v][24:17], VEC[v][16:9], int'(VEC[v][8:1]), VEC[v][0]);
      frame_check(VEC[v][26:25] == 2'd2, int'(VEC[v][8:1]),
                  (VEC[v][26:25] == 2'd2) ? "R6_R7_R8" : "R3_R4_R5");
    end

    // R2 wake-up: no output, remembered address untouched
    build(2'd0, 8'h03, 8'h00, 8, 1'b0);
    frame_check(1'b0, 8, "R3");
    frame_check(1'b0, 0, "R2");
    build(2'd2, 8'h04, 8'h11, 4, 1'b0);
    frame_check(1'b1, 4, "R2");
    check(got_stv == 1'b1, "R2", got_stv, 1);

    // R9 overflow
    build(2'd0, 8'h03, 8'h00, DEPTH + 1, 1'b0);
    frame_check(1'b0, DEPTH + 1, "R9");
    check(got_err == 1'b1 && got_n == 0, "R9", got_n, 0);

    // R10 repeated start aborts partial frame
    send(3'd0, 8'h00);
    send(3'd2, 8'h00);
    send(3'd3, 8'h01);
    send(3'd3, 8'h77);
    send(3'd3, 8'h78);
    build(2'd0, 8'h03, 8'h00, 9, 1'b0);
    frame_check(1'b0, 9, "R10");
    check(got_n == 9 && got_byte[0] == 8'h03, "R10", got_byte[0], 8'h03);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule